// File: doc/BRIEF.md
# Table-Backed Instruction Widener

This block turns a stream of 16-bit instruction words into 96-bit control words for a data path. Most opcodes pass through a small fixed decoder. That decoder produces a 32-bit native control word, which is zero-extended onto the 96-bit output bus. One opcode class has its top byte equal to 8'hFF. For that class the low byte is only an index. It selects one of 256 wide control words held in a writable context table, and that stored word becomes the output. The opcode carries no configuration bits of its own.

An external loader fills the context table through a separate write port. This port runs independently of decoding, so the loader can replace contexts while instructions keep flowing and the instruction set can change at run time. Each accepted instruction yields one control word, registered, on the following clock.

Top module: `insn_widener`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, ctrl_valid is 0 and ctrl_word is all zero.
- R2: ctrl_valid in cycle n+1 equals insn_valid in cycle n, so there is exactly one registered cycle of latency.
- R3: When insn_valid is 0 in cycle n, ctrl_word in cycle n+1 is all zero.
- R4: An accepted instruction whose bits [15:8] equal 8'hFF produces, one cycle later, the 96-bit table entry addressed by bits [7:0], as last written before the cycle of acceptance.
- R5: An accepted instruction whose bits [15:12] hold a major code m from 1 to 4 produces ctrl_word[31:24] = 1 << (m-1), ctrl_word[23:12] = 0, ctrl_word[11:0] = instruction bits [11:0], and ctrl_word[95:32] = 0.
- R6: Any other accepted instruction produces an all-zero control word. This covers major code 0, codes 5 to 15, and top bytes 8'hF0 to 8'hFE.
- R7: A write with tbl_wr_en high in cycle n stores tbl_wr_data at tbl_wr_addr. The stored value is visible to table-class instructions accepted from cycle n+1 onward. Writes do not stall decoding or change the control words for other entries.
- R8: When a write and a table-class decode target the same entry in the same cycle, the decode returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_valid | input | 1 | Instruction present this cycle |
| insn | input | 16 | Short instruction word |
| tbl_wr_en | input | 1 | Context table write strobe |
| tbl_wr_addr | input | 8 | Context table entry to write |
| tbl_wr_data | input | 96 | Wide control word to store |
| ctrl_valid | output | 1 | Control word present this cycle |
| ctrl_word | output | 96 | Wide control word |

## Verification
The bench first loads every table entry with a distinct pattern and reads each one back. This shows that indexing reaches all 256 entries and that the table path is kept apart from the fixed path. Native opcodes of every major code are then mixed with unknown codes and with near-miss top bytes such as 8'hFE. These show the fixed decoder's one-hot select and its zero fallback. Random traffic then interleaves writes and table reads with idle gaps, which checks the latency and the idle zeroing. Forced same-entry collisions tell read-before-write apart from write-through.

// File: rtl/widen_pkg.sv
// Package: shared sizes and opcode codes for the instruction widener.
// Assumes the table index sits in the low bits of the instruction word.
package widen_pkg;
    localparam int INSN_W   = 16;
    localparam int IDX_W    = 8;
    localparam int CTRL_W   = 96;
    localparam int NATIVE_W = 32;
    localparam int FN_W     = 8;
    localparam int NUM_OPS  = 4;
    localparam int TAG_W    = INSN_W - IDX_W;
    localparam logic [TAG_W-1:0] TBL_TAG = '1;

    typedef enum logic [3:0] {
        MAJ_NOP = 4'd0,
        MAJ_ADD = 4'd1,
        MAJ_SUB = 4'd2,
        MAJ_AND = 4'd3,
        MAJ_OR  = 4'd4
    } major_e;
endpackage

// File: rtl/fixed_decode.sv
// fixed_decode: hardwired decoder for native opcodes.
// The major code in the top nibble picks a one-hot function select; the
// low 12 bits pass through as operand fields. Unknown codes give zero.
// Assumes NUM_OPS <= FN_W and that the caller screens out the table class.
module fixed_decode
    import widen_pkg::*;
#(
    parameter int IW  = INSN_W,
    parameter int NW  = NATIVE_W,
    parameter int FW  = FN_W,
    parameter int NOP = NUM_OPS
) (
    input  logic [IW-1:0] insn,
    output logic [NW-1:0] native
);
    localparam int FIELD_W = IW - 4;
    localparam int GAP_W   = NW - FW - FIELD_W;

    logic [3:0]    major;
    logic [FW-1:0] fsel;

    assign major = insn[IW-1 -: 4];

    // One comparator per native function, placing its select bit.
    genvar g;
    generate
        for (g = 0; g < FW; g++) begin : g_sel
            if (g < NOP) begin : g_live
                assign fsel[g] = (major == 4'(g + 1));
            end else begin : g_dead
                assign fsel[g] = 1'b0;
            end
        end
    endgenerate

    // Assemble the native word, or a zero no-op on an unknown code.
    always_comb begin
        if (|fsel) native = {fsel, {GAP_W{1'b0}}, insn[FIELD_W-1:0]};
        else       native = '0;
    end
endmodule

// File: rtl/ctx_table.sv
// ctx_table: writable store of wide control words.
// The read is combinational from the index; the write lands on the clock
// edge, so a read in the same cycle as a write to that entry sees old data.
// Contents are not reset; the loader must fill entries before use.
module ctx_table #(
    parameter int AW = 8,
    parameter int DW = 96
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store one loader word per cycle.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Present the addressed entry.
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/insn_widener.sv
// insn_widener: top of the table-backed instruction widener.
// Table-class words (top byte all ones) select a stored context word;
// all others go through the fixed decoder, zero-extended. The output is
// registered once. Reset is synchronous and active low.
module insn_widener
    import widen_pkg::*;
#(
    parameter int IW = INSN_W,
    parameter int AW = IDX_W,
    parameter int CW = CTRL_W,
    parameter int NW = NATIVE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          insn_valid,
    input  logic [IW-1:0] insn,
    input  logic          tbl_wr_en,
    input  logic [AW-1:0] tbl_wr_addr,
    input  logic [CW-1:0] tbl_wr_data,
    output logic          ctrl_valid,
    output logic [CW-1:0] ctrl_word
);
    localparam int TW = IW - AW;

    logic          is_tbl;
    logic [CW-1:0] tbl_word;
    logic [NW-1:0] native;
    logic [CW-1:0] next_word;

    assign is_tbl = (insn[IW-1 -: TW] == {TW{1'b1}});

    ctx_table #(.AW(AW), .DW(CW)) u_table (
        .clk     (clk),
        .wr_en   (tbl_wr_en),
        .wr_addr (tbl_wr_addr),
        .wr_data (tbl_wr_data),
        .rd_addr (insn[AW-1:0]),
        .rd_data (tbl_word)
    );

    fixed_decode #(.IW(IW), .NW(NW)) u_fixed (
        .insn   (insn),
        .native (native)
    );

    // Choose between stored context and widened native word.
    always_comb begin
        if (is_tbl) next_word = tbl_word;
        else        next_word = {{(CW-NW){1'b0}}, native};
    end

    // Register the control word and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_valid <= 1'b0;
            ctrl_word  <= '0;
        end else begin
            ctrl_valid <= insn_valid;
            ctrl_word  <= insn_valid ? next_word : '0;
        end
    end
endmodule

// File: rtl/insn_widener_chk.sv
// insn_widener_chk: temporal properties of the widener's ports.
// Bound to every insn_widener instance below.
module insn_widener_chk #(
    parameter int IW = 16,
    parameter int AW = 8,
    parameter int CW = 96,
    parameter int NW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          insn_valid,
    input logic [IW-1:0] insn,
    input logic          ctrl_valid,
    input logic [CW-1:0] ctrl_word
);
    localparam int TW = IW - AW;

    logic tbl_cls;
    logic known_op;
    assign tbl_cls  = (insn[IW-1 -: TW] == {TW{1'b1}});
    assign known_op = (insn[IW-1 -: 4] >= 4'd1) && (insn[IW-1 -: 4] <= 4'd4);

    // R1: reset clears the outputs on the following edge
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!ctrl_valid && ctrl_word == '0));

    // R2: valid travels through exactly one register
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid |=> ctrl_valid);
    p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> !ctrl_valid);

    // R3: idle cycles leave a zero word
    p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> ctrl_word == '0);

    // R5: native words never reach above the native width, and select one function
    p_native_narrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && !tbl_cls) |=> ctrl_word[CW-1:NW] == '0);
    p_native_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && known_op) |=> $countones(ctrl_word[NW-1 -: 8]) == 1);

    // R6: unknown opcodes give a zero word
    p_unknown_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && !tbl_cls && !known_op) |=> ctrl_word == '0);
endmodule

bind insn_widener insn_widener_chk #(.IW(IW), .AW(AW), .CW(CW), .NW(NW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_valid (insn_valid),
    .insn       (insn),
    .ctrl_valid (ctrl_valid),
    .ctrl_word  (ctrl_word)
);

// File: tb/insn_widener_test.sv
`timescale 1ns/1ps
module insn_widener_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [15:0] insn = '0;
    logic        tbl_wr_en = 1'b0;
    logic [7:0]  tbl_wr_addr = '0;
    logic [95:0] tbl_wr_data = '0;
    logic        ctrl_valid;
    logic [95:0] ctrl_word;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;
    int unsigned seed = 32'h1234_5678;

    logic [95:0] ref_tbl [256];
    logic        exp_valid = 1'b0;
    logic [95:0] exp_word = '0;
    string       exp_tag = "R1";

    insn_widener uut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
        .ctrl_valid(ctrl_valid), .ctrl_word(ctrl_word)
    );

    always #2 clk = ~clk;

    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    function automatic logic [95:0] pattern(input int a, input int gen);
        return {8'(a), 8'(gen), 16'hC0DE, 32'(a * 977 + gen), 32'(~(a * 31 + gen * 7))};
    endfunction

    // Behavioural model of the fixed path.
    function automatic logic [95:0] native_model(input logic [15:0] w);
        logic [95:0] r;
        r = '0;
        case (w[15:12])
            4'd1: r[31:24] = 8'h01;
            4'd2: r[31:24] = 8'h02;
            4'd3: r[31:24] = 8'h04;
            4'd4: r[31:24] = 8'h08;
            default: return '0;
        endcase
        r[11:0] = w[11:0];
        return r;
    endfunction

    task automatic compare();
        checks++;
        if (ctrl_valid !== exp_valid || ctrl_word !== exp_word) begin
            failures++;
            $display("FAIL %s: got valid=%0b word=%h expected valid=%0b word=%h",
                     exp_tag, ctrl_valid, ctrl_word, exp_valid, exp_word);
        end
    endtask

    // One cycle: check the previous result, drive new inputs, update the model.
    task automatic step(input bit v, input logic [15:0] w, input bit we,
                        input logic [7:0] wa, input logic [95:0] wd, input string tag);
        @(negedge clk);
        compare();
        insn_valid = v; insn = w;
        tbl_wr_en = we; tbl_wr_addr = wa; tbl_wr_data = wd;
        exp_valid = v;
        exp_tag = tag;
        if (!v) exp_word = '0;
        else if (w[15:8] == 8'hFF) exp_word = ref_tbl[w[7:0]];
        else exp_word = native_model(w);
        if (we) ref_tbl[wa] = wd;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ref_tbl[i] = '0;
        // R1: outputs held clear during reset
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (ctrl_valid !== 1'b0 || ctrl_word !== '0) begin
                failures++;
                $display("FAIL R1: got valid=%0b word=%h expected 0 and zero", ctrl_valid, ctrl_word);
            end
        end
        rst_n = 1'b1;
        exp_valid = 1'b0; exp_word = '0; exp_tag = "R1";
        // R7: fill every entry while idle (R3 idle zero checked too)
        for (int a = 0; a < 256; a++) step(0, 16'h0, 1, 8'(a), pattern(a, 1), "R3");
        // R4: read every entry back
        for (int a = 0; a < 256; a++) step(1, {8'hFF, 8'(a)}, 0, 8'h0, '0, "R4");
        // R5: every native major code with varied fields
        for (int m = 1; m <= 4; m++) begin
            step(1, {4'(m), 12'hFFF}, 0, 0, '0, "R5");
            step(1, {4'(m), 12'h5A3}, 0, 0, '0, "R5");
            step(1, {4'(m), 12'h000}, 0, 0, '0, "R5");
        end
        // R6: unknown majors and near-miss tags
        step(1, 16'h0ABC, 0, 0, '0, "R6");
        for (int m = 5; m < 16; m++) step(1, {4'(m), 12'h123}, 0, 0, '0, "R6");
        step(1, 16'hFE07, 0, 0, '0, "R6");
        step(1, 16'hF0FF, 0, 0, '0, "R6");
        // R8: same-entry collision returns old data, next read sees new
        step(1, 16'hFF10, 1, 8'h10, pattern(16, 2), "R8");
        step(1, 16'hFF10, 0, 0, '0, "R7");
        step(1, 16'hFFFF, 1, 8'hFF, pattern(255, 3), "R8");
        step(1, 16'hFF00, 1, 8'hFF, pattern(255, 4), "R7");
        step(1, 16'hFFFF, 0, 0, '0, "R7");
        step(0, 16'hFFFF, 0, 0, '0, "R2");
        // R2/R7: random mixed traffic with concurrent writes
        for (int k = 0; k < 3000; k++) begin
            int unsigned r;
            bit v, we;
            logic [15:0] w;
            logic [7:0] wa;
            r = rnd();
            v = (r % 4) != 0;
            we = ((r >> 4) % 3) == 0;
            wa = 8'(r >> 8) & 8'h1F;
            if (((r >> 16) % 2) == 0) w = {8'hFF, 3'b000, 5'(rnd())};
            else w = 16'(rnd());
            if (((r >> 20) % 8) == 0) begin
                w = {8'hFF, wa};
                v = 1; we = 1;
            end
            step(v, w, we, wa, pattern(int'(wa), k + 10), (we && v && w[15:8] == 8'hFF && w[7:0] == wa) ? "R8" : "R7");
        end
        step(0, 16'h0, 0, 0, '0, "R2");
        step(0, 16'h0, 0, 0, '0, "R2");
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog: got %0d cycles expected fewer than 150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule